// File: doc/BRIEF.md
# SCSI Synchronous Offset and Gross-Error Checker

This block watches one SCSI data path and reports misuse of it. It counts the outstanding synchronous offset from the REQ and ACK strobes. It also checks the traffic into and out of the data FIFO, bus phase changes and transfer starts against the rules of synchronous transfer. When a rule is broken it raises a single-cycle gross-error pulse together with a cause code. The interrupt logic that sits next to it latches these.

The REQ strobe always adds one to the offset and the ACK strobe always takes one away. The mode input decides which side owns each strobe. In initiator mode REQ comes from the peer and ACK is driven locally. In target mode REQ is driven locally and ACK comes from the peer. A maximum-offset setting of zero selects asynchronous operation. In that mode the offset checks are switched off and the count is held at zero. The FIFO checks stay active in both modes.

All checks look at the inputs in one clock cycle. The result appears on the outputs after the next rising edge.

Top module: `scsi_offset_guard`

## Requirements
- R1: After synchronous reset, `gross_err` is 0, `err_cause` is 0 and the outstanding offset is 0.
- R2: A FIFO read strobe while `fifo_level` is 0 is a data underflow, cause code 1.
- R3: A FIFO write strobe while `fifo_level` equals FIFO_DEPTH (default 8) is a data overflow, cause code 2.
- R4: In target mode (`is_target`=1), an ACK strobe without a REQ strobe while the offset is 0 is an offset underflow, cause code 3. The same stimulus in initiator mode is not an error.
- R5: A REQ strobe without an ACK strobe while the offset is already at or above `max_offset` is an offset overflow, cause code 4. The increment is still counted, up to saturation.
- R6: REQ and ACK strobes in the same cycle leave the offset unchanged and raise no offset error.
- R7: In initiator mode, a change of `bus_phase` from the previous cycle while the offset is nonzero is an error, cause code 5. There is no such error in target mode or when the offset is 0.
- R8: A transfer-start strobe whose `xfer_kind` is not 0 (0 = synchronous receive, 1 = synchronous send, 2 = asynchronous receive, 3 = asynchronous send) while `fifo_level` is nonzero is a residual-data error, cause code 6.
- R9: With `max_offset` = 0 the checks for codes 3, 4 and 5 never fire and the offset is held at 0.
- R10: When several conditions hold in one cycle, only one pulse is issued and `err_cause` gives the lowest code among them.
- R11: The offset saturates at 2^OFS_W-1 (31 by default) and at 0. It never wraps.
- R12: `gross_err` rises exactly one cycle after the offending input cycle and lasts one cycle unless the next cycle also errs. `err_cause` is 0 whenever `gross_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pulse | input | 1 | One-cycle REQ strobe (adds to the offset) |
| ack_pulse | input | 1 | One-cycle ACK strobe (takes from the offset) |
| is_target | input | 1 | 1 = target mode, 0 = initiator mode |
| max_offset | input | OFS_W | Programmed maximum offset; 0 selects asynchronous mode |
| bus_phase | input | PH_W | Current bus phase code |
| fifo_rd | input | 1 | FIFO read strobe |
| fifo_wr | input | 1 | FIFO write strobe |
| fifo_level | input | LVL_W | Current FIFO occupancy |
| xfer_start | input | 1 | Transfer-start strobe |
| xfer_kind | input | 2 | Kind of the transfer being started |
| gross_err | output | 1 | One-cycle gross-error pulse |
| err_cause | output | 3 | Cause code for the pulse, 0 when idle |

## Verification
The offset counter is driven in several patterns, and each pattern separates one behaviour from the others. Runs of REQs up to the limit and one past it find an off-by-one in the overflow compare. A combined REQ+ACK at the limit, followed by a single REQ, shows that the simultaneous pair left the count alone. Draining with ACKs down to an underflow in target mode shows both that the count is exact and that the mode gate works. Filling to 31 and past it, then draining 31 times before the underflow, separates saturation from wrap-around. A REQ run in asynchronous mode followed by a target ACK shows that the count was held at zero. Phase changes are tried with zero and nonzero offsets and in both modes. Stacked conditions check the priority order.

// File: rtl/sog_pkg.sv
package sog_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_DATA_UNDER = 3'd1,
        CAUSE_DATA_OVER  = 3'd2,
        CAUSE_OFS_UNDER  = 3'd3,
        CAUSE_OFS_OVER   = 3'd4,
        CAUSE_PHASE      = 3'd5,
        CAUSE_RESIDUAL   = 3'd6
    } cause_e;

    typedef enum logic [1:0] {
        XK_SYNC_RX  = 2'd0,
        XK_SYNC_TX  = 2'd1,
        XK_ASYNC_RX = 2'd2,
        XK_ASYNC_TX = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic data_under;
        logic data_over;
        logic ofs_under;
        logic ofs_over;
        logic phase_chg;
        logic residual;
    } err_flags_t;

    // Lowest-numbered condition wins.
    function automatic cause_e pick_cause(err_flags_t f);
        if (f.data_under)     return CAUSE_DATA_UNDER;
        else if (f.data_over) return CAUSE_DATA_OVER;
        else if (f.ofs_under) return CAUSE_OFS_UNDER;
        else if (f.ofs_over)  return CAUSE_OFS_OVER;
        else if (f.phase_chg) return CAUSE_PHASE;
        else if (f.residual)  return CAUSE_RESIDUAL;
        else                  return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/offset_tracker.sv
module offset_tracker #(
    parameter int OFS_W = 5,
    parameter int PH_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_pulse,
    input  logic             ack_pulse,
    input  logic             is_target,
    input  logic [OFS_W-1:0] max_offset,
    input  logic [PH_W-1:0]  bus_phase,
    output logic             ofs_under,
    output logic             ofs_over,
    output logic             phase_chg
);
    localparam logic [OFS_W-1:0] CNT_TOP = '1;

    logic [OFS_W-1:0] cnt_q;
    logic [PH_W-1:0]  phase_q;
    logic             sync_on;
    logic             up_only;
    logic             down_only;

    always_comb begin
        sync_on   = (max_offset != '0);
        up_only   = req_pulse && !ack_pulse;
        down_only = ack_pulse && !req_pulse;
        ofs_over  = sync_on && up_only && (cnt_q >= max_offset);
        ofs_under = sync_on && is_target && down_only && (cnt_q == '0);
        phase_chg = sync_on && !is_target && (cnt_q != '0) && (bus_phase != phase_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= '0;
        end else begin
            phase_q <= bus_phase;
            if (!sync_on)
                cnt_q <= '0;
            else if (up_only && cnt_q != CNT_TOP)
                cnt_q <= cnt_q + 1'b1;
            else if (down_only && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // R11: no wrap at the top
    assert_sat_top_R11: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_TOP && up_only && sync_on) |=> (cnt_q == CNT_TOP));
    // R11: no wrap at the bottom
    assert_sat_floor_R11: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && down_only) |=> (cnt_q == '0));
    // R6: paired strobes hold the count
    assert_pair_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (req_pulse && ack_pulse && sync_on) |=> $stable(cnt_q));
    // R9: asynchronous mode keeps the count at zero
    assert_async_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (!sync_on) |=> (cnt_q == '0));

endmodule

// File: rtl/fifo_misuse_check.sv
module fifo_misuse_check
    import sog_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int LVL_W      = 4
) (
    input  logic             fifo_rd,
    input  logic             fifo_wr,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             xfer_start,
    input  logic [1:0]       xfer_kind,
    output logic             data_under,
    output logic             data_over,
    output logic             residual
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

    always_comb begin
        data_under = fifo_rd && (fifo_level == '0);
        data_over  = fifo_wr && (fifo_level >= FULL_LVL);
        residual   = xfer_start && (xfer_kind_e'(xfer_kind) != XK_SYNC_RX)
                     && (fifo_level != '0);
    end

endmodule

// File: rtl/gross_err_report.sv
module gross_err_report
    import sog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_flags_t flags,
    output logic       gross_err,
    output logic [2:0] err_cause
);
    logic   any_err;
    cause_e cause_d;

    always_comb begin
        any_err = (flags != '0);
        cause_d = pick_cause(flags);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gross_err <= 1'b0;
            err_cause <= CAUSE_NONE;
        end else begin
            gross_err <= any_err;
            err_cause <= cause_d;
        end
    end

    // R12: one condition cycle gives a pulse on the next cycle
    assert_pulse_next_R12: assert property (@(posedge clk) disable iff (rst)
        any_err |=> gross_err);
    // R12: quiet cycle gives idle outputs
    assert_quiet_next_R12: assert property (@(posedge clk) disable iff (rst)
        !any_err |=> (!gross_err && err_cause == 3'd0));
    // R10: the underflow condition outranks every other one
    assert_prio_top_R10: assert property (@(posedge clk) disable iff (rst)
        flags.data_under |=> (err_cause == 3'd1));
    // R10: the residual code only shows when it stands alone
    assert_prio_last_R10: assert property (@(posedge clk) disable iff (rst)
        (flags.residual && flags.data_over) |=> (err_cause == 3'd2));

endmodule

// File: rtl/scsi_offset_guard.sv
module scsi_offset_guard
    import sog_pkg::*;
#(
    parameter int   OFS_W      = 5,
    parameter int   PH_W       = 3,
    parameter int   FIFO_DEPTH = 8,
    localparam int  LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_pulse,
    input  logic             ack_pulse,
    input  logic             is_target,
    input  logic [OFS_W-1:0] max_offset,
    input  logic [PH_W-1:0]  bus_phase,
    input  logic             fifo_rd,
    input  logic             fifo_wr,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             xfer_start,
    input  logic [1:0]       xfer_kind,
    output logic             gross_err,
    output logic [2:0]       err_cause
);
    err_flags_t flags;

    offset_tracker #(.OFS_W(OFS_W), .PH_W(PH_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .req_pulse  (req_pulse),
        .ack_pulse  (ack_pulse),
        .is_target  (is_target),
        .max_offset (max_offset),
        .bus_phase  (bus_phase),
        .ofs_under  (flags.ofs_under),
        .ofs_over   (flags.ofs_over),
        .phase_chg  (flags.phase_chg)
    );

    fifo_misuse_check #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
        .fifo_rd    (fifo_rd),
        .fifo_wr    (fifo_wr),
        .fifo_level (fifo_level),
        .xfer_start (xfer_start),
        .xfer_kind  (xfer_kind),
        .data_under (flags.data_under),
        .data_over  (flags.data_over),
        .residual   (flags.residual)
    );

    gross_err_report u_report (
        .clk       (clk),
        .rst       (rst),
        .flags     (flags),
        .gross_err (gross_err),
        .err_cause (err_cause)
    );

    // R2: reading an empty FIFO always reports code 1 next cycle
    assert_empty_read_R2: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd && fifo_level == '0) |=> (gross_err && err_cause == 3'd1));
    // R3: writing a full FIFO always raises the pulse
    assert_full_write_R3: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && fifo_level == LVL_W'(FIFO_DEPTH)) |=> gross_err);
    // R9: asynchronous mode never reports an offset or phase code
    assert_async_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (max_offset == '0) |=> (err_cause != 3'd3 && err_cause != 3'd4 && err_cause != 3'd5));

endmodule

// File: tb/scsi_offset_guard_bench.sv
`timescale 1ns/100ps
module scsi_offset_guard_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_pulse = 0, ack_pulse = 0, is_target = 0;
    logic [4:0] max_offset = 5'd4;
    logic [2:0] bus_phase = 3'd0;
    logic       fifo_rd = 0, fifo_wr = 0, xfer_start = 0;
    logic [3:0] fifo_level = 4'd0;
    logic [1:0] xfer_kind = 2'd0;
    logic       gross_err;
    logic [2:0] err_cause;

    // configuration staged by the sequence, applied at the drive edge
    logic       cfg_tgt = 0;
    logic [4:0] cfg_max = 5'd4;
    logic [2:0] cfg_phase = 3'd0;

    typedef struct {
        logic [2:0] cause;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    scsi_offset_guard u_scsi_offset_guard (
        .clk(clk), .rst(rst),
        .req_pulse(req_pulse), .ack_pulse(ack_pulse), .is_target(is_target),
        .max_offset(max_offset), .bus_phase(bus_phase),
        .fifo_rd(fifo_rd), .fifo_wr(fifo_wr), .fifo_level(fifo_level),
        .xfer_start(xfer_start), .xfer_kind(xfer_kind),
        .gross_err(gross_err), .err_cause(err_cause)
    );

    task automatic go(input logic rq, input logic ak, input logic rd, input logic wr,
                      input logic st, input logic [3:0] lv, input logic [1:0] kd,
                      input logic [2:0] exp_cause, input string tag);
        exp_t e;
        @(negedge clk);
        is_target  = cfg_tgt;
        max_offset = cfg_max;
        bus_phase  = cfg_phase;
        req_pulse  = rq;
        ack_pulse  = ak;
        fifo_rd    = rd;
        fifo_wr    = wr;
        xfer_start = st;
        fifo_level = lv;
        xfer_kind  = kd;
        e.cause = exp_cause;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input logic [2:0] exp_cause, input string tag);
        go(0, 0, 0, 0, 0, 4'd0, 2'd0, exp_cause, tag);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // monitor: one expected item per clock, compared after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (gross_err !== (e.cause != 3'd0) || err_cause !== e.cause) begin
                    n_bad++;
                    $display("FAIL %s: gross_err=%0b cause=%0d expected gross_err=%0b cause=%0d",
                             e.tag, gross_err, err_cause, (e.cause != 3'd0), e.cause);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        n_vec++;
        if (gross_err !== 1'b0 || err_cause !== 3'd0) begin
            n_bad++;
            $display("FAIL R1: gross_err=%0b cause=%0d expected 0/0", gross_err, err_cause);
        end

        // R1 / R4: count starts at zero, so a target ACK underflows at once
        cfg_tgt = 1;
        go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd3, "R1 R4 target ack at zero");
        idle(3'd0, "R12 pulse lasts one cycle");

        // R2: data underflow
        go(0, 0, 1, 0, 0, 4'd0, 2'd0, 3'd1, "R2 read empty");
        go(0, 0, 1, 0, 0, 4'd3, 2'd0, 3'd0, "R2 read nonempty");
        // R3: data overflow
        go(0, 0, 0, 1, 0, 4'd8, 2'd0, 3'd2, "R3 write full");
        go(0, 0, 0, 1, 0, 4'd7, 2'd0, 3'd0, "R3 write one below full");

        // R5 / R6 in initiator mode, max 4
        cfg_tgt = 0;
        for (int i = 0; i < 4; i++) go(1, 0, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R5 fill to limit");
        go(1, 1, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R6 paired strobes at limit");
        go(1, 0, 0, 0, 0, 4'd0, 2'd0, 3'd4, "R5 R6 req past limit");
        for (int i = 0; i < 5; i++) go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R5 drain");
        go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R4 initiator ack at zero ignored");

        // R7: phase change
        go(1, 0, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R7 offset to one");
        cfg_phase = 3'd3;
        idle(3'd5, "R7 phase change with offset");
        idle(3'd0, "R7 phase steady");
        go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R7 offset to zero");
        cfg_phase = 3'd5;
        idle(3'd0, "R7 phase change with zero offset");
        cfg_tgt = 1;
        go(1, 0, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R7 target offset to one");
        cfg_phase = 3'd2;
        idle(3'd0, "R7 target phase change ignored");
        go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R7 target drain");

        // R8: residual data
        go(0, 0, 0, 0, 1, 4'd2, 2'd1, 3'd6, "R8 sync send with data");
        go(0, 0, 0, 0, 1, 4'd2, 2'd0, 3'd0, "R8 sync receive with data");
        go(0, 0, 0, 0, 1, 4'd0, 2'd1, 3'd0, "R8 sync send empty");
        go(0, 0, 0, 0, 1, 4'd5, 2'd3, 3'd6, "R8 async send with data");

        // R9: asynchronous mode
        cfg_max = 5'd0;
        cfg_tgt = 0;
        for (int i = 0; i < 6; i++) go(1, 0, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R9 req in async");
        cfg_phase = 3'd6;
        idle(3'd0, "R9 phase change in async");
        cfg_tgt = 1;
        go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R9 target ack in async");
        cfg_max = 5'd4;
        go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd3, "R9 count held at zero");

        // R10: priority
        cfg_tgt = 0;
        for (int i = 0; i < 4; i++) go(1, 0, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R10 fill");
        go(1, 0, 1, 0, 0, 4'd0, 2'd0, 3'd1, "R10 underflow beats offset overflow");
        idle(3'd0, "R10 single pulse");
        go(0, 0, 0, 1, 1, 4'd8, 2'd1, 3'd2, "R10 overflow beats residual");
        for (int i = 0; i < 5; i++) go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R10 drain");
        cfg_tgt = 1;
        go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd3, "R10 drain left zero");

        // R11: saturation at 31
        cfg_max = 5'd31;
        for (int i = 0; i < 31; i++) go(1, 0, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R11 fill to 31");
        go(1, 0, 0, 0, 0, 4'd0, 2'd0, 3'd4, "R11 req at saturation");
        for (int i = 0; i < 31; i++) go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd0, "R11 drain 31");
        go(0, 1, 0, 0, 0, 4'd0, 2'd0, 3'd3, "R11 underflow after drain");
        idle(3'd0, "R12 final idle");

        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule